// File: doc/BRIEF.md
# Single-Wire Serial Target Responder

This block is the target end of a single-wire, open-drain, return-to-one serial bus. An external pullup holds the line high. Both the host and the target signal only by pulling the line low. Each bit cell starts with a falling edge, and the length of the low pulse carries the bit value. The block watches an already-synchronised copy of the line and owns one drive-low output. It decodes incoming bits by measuring their low time and assembles a command of a 7-bit register address plus a direction flag. It then either stores the data bits that follow into a 128 x 8 register file, or answers with the register contents after a fixed reply delay.

An input selects 8-bit or 16-bit data. In 16-bit mode the addressed register supplies the low byte and the next address supplies the high byte. The address wraps from 127 back to 0. A side port lets local logic preload any register and read any register at any time. The host may leave the line high for as long as it likes between bits. A very long low pulse resets the bus, and the block then waits for a fresh command.

Top module: `swt_target`

## Requirements
- R1: A command is 8 received bits, least significant bit first: bits 0..6 form the register address, and bit 7 is the direction flag (1 = write, 0 = read).
- R2: A received bit whose line-low time lasts fewer than ONE_MAX_LOW clock cycles decodes as 1. A low time of ONE_MAX_LOW cycles or more (but under BREAK_LOW) decodes as 0.
- R3: In 8-bit mode (`wide_i`=0), after a write command the next 8 received bits, LSB first, are stored into the addressed register.
- R4: After a read command, the block sends the addressed register least significant bit first. Each bit occupies a cell of CELL cycles. A 1 is a low pulse of TX_LOW_ONE cycles and a 0 is a low pulse of TX_LOW_ZERO cycles.
- R5: The first reply bit's falling edge comes exactly REPLY_DELAY clock cycles after the falling edge of the command's direction bit is seen. REPLY_DELAY is required to be at least CELL.
- R6: Any length of high time between consecutive command or write-data bits is accepted without changing the result.
- R7: The block only pulls the line low or releases it. `drive_low_o` is asserted only while a reply is being sent, and each of its low pulses lasts either TX_LOW_ONE or TX_LOW_ZERO cycles.
- R8: In 16-bit mode (`wide_i`=1), 16 data bits follow the command. A write stores bits 0..7 at the address and bits 8..15 at the address plus one, modulo 128. A read sends the same two registers in the same bit order.
- R9: A line-low time of BREAK_LOW cycles or more abandons any partial transaction and returns the block to waiting for a command.
- R10: Edges caused by the block's own drive-low output are never decoded as incoming bits, so a command that follows a reply is decoded correctly.
- R11: Reset clears every register to 0 and releases the line. A local write (`loc_wr_i`) stores `loc_wdata_i` at `loc_addr_i` on the next clock edge, and `loc_rdata_o` shows the register at `loc_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Synchronised bus line level (1 = high) |
| drive_low_o | output | 1 | 1 pulls the bus line low, 0 releases it |
| wide_i | input | 1 | 0 = 8 data bits per transaction, 1 = 16 data bits |
| loc_addr_i | input | 7 | Local register address |
| loc_wr_i | input | 1 | Local write strobe |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Register contents at loc_addr_i |

## Verification
The bench builds the block with REPLY_DELAY equal to CELL (20 cycles), the smallest delay allowed. The first reply edge therefore falls in the cycle the direction bit's cell would end, and the delay check sits on its tightest boundary. ONE_MAX_LOW is 8 so that host pulses of 7 and 8 cycles probe both sides of the bit-decision threshold. BREAK_LOW is 40, which is short enough to trigger a bus reset in a few dozen cycles and still well clear of the 12-cycle data pulses. The defaults for TX_LOW_ONE (4) and TX_LOW_ZERO (12) stay in place, so reply pulses are told apart by length alone.

// File: rtl/swt_pkg.sv
// Shared types for the single-wire target responder.
package swt_pkg;

    // Transaction phase of the responder
    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,   // collecting address and direction bits
        ST_WDATA = 2'd1,   // collecting write data bits
        ST_WAIT  = 2'd2,   // holding off until the reply delay elapses
        ST_SEND  = 2'd3    // transmitter is sending the reply
    } swt_state_e;

endpackage

// File: rtl/swt_rx.sv
// Pulse-width bit receiver.
// Measures each low period of the line. A period shorter than ONE_MAX_LOW
// cycles is a 1, otherwise a 0. A period reaching BREAK_LOW cycles is
// reported once as a bus break and yields no bit.
// Assumes line_i is already synchronised and ONE_MAX_LOW < BREAK_LOW.
// While mute_i is high the line is not decoded.
module swt_rx #(
    parameter int ONE_MAX_LOW = 8,
    parameter int BREAK_LOW   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic mute_i,
    output logic fall_o,
    output logic bit_vld_o,
    output logic bit_o,
    output logic brk_o
);
    localparam int LCW = $clog2(BREAK_LOW + 1);

    logic           prev_q;
    logic           low_act_q;
    logic           brk_seen_q;
    logic [LCW-1:0] lc_q;

    // A falling edge not caused by our own drive
    assign fall_o = prev_q & ~line_i & ~mute_i;

    // Low-time measurement, bit decision and break detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b1;
            low_act_q  <= 1'b0;
            brk_seen_q <= 1'b0;
            lc_q       <= '0;
            bit_vld_o  <= 1'b0;
            bit_o      <= 1'b0;
            brk_o      <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            brk_o     <= 1'b0;
            prev_q    <= line_i;
            if (mute_i) begin
                low_act_q <= 1'b0;
            end else if (fall_o) begin
                low_act_q  <= 1'b1;
                brk_seen_q <= 1'b0;
                lc_q       <= LCW'(1);
            end else if (low_act_q && !line_i) begin
                if (lc_q != LCW'(BREAK_LOW))
                    lc_q <= lc_q + 1'b1;
                if (lc_q == LCW'(BREAK_LOW - 1) && !brk_seen_q) begin
                    brk_o      <= 1'b1;
                    brk_seen_q <= 1'b1;
                end
            end else if (low_act_q && line_i) begin
                low_act_q <= 1'b0;
                if (!brk_seen_q) begin
                    bit_vld_o <= 1'b1;
                    bit_o     <= (lc_q < LCW'(ONE_MAX_LOW));
                end
            end
        end
    end

endmodule

// File: rtl/swt_tx.sv
// Pulse-width bit transmitter.
// On start_i it sends 8 or 16 bits of data_i, LSB first. Each bit lasts
// CELL cycles and begins with a low pulse of LOW_ONE (bit 1) or LOW_ZERO
// (bit 0) cycles. Assumes LOW_ONE and LOW_ZERO are both in 1..CELL-1.
// The output only ever means "pull low".
module swt_tx #(
    parameter int CELL     = 20,
    parameter int LOW_ONE  = 4,
    parameter int LOW_ZERO = 12,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          wide_i,
    input  logic [DW-1:0] data_i,
    output logic          drive_low_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam int CW = $clog2(CELL);
    localparam int BW = $clog2(DW);

    logic [DW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] idx_q;
    logic [BW-1:0] last_idx;
    logic [CW:0]   low_len;
    logic [CW:0]   cnt_nx;

    assign last_idx = wide_i ? BW'(DW - 1) : BW'(DW / 2 - 1);
    assign low_len  = sh_q[0] ? (CW+1)'(LOW_ONE) : (CW+1)'(LOW_ZERO);
    assign cnt_nx   = {1'b0, cnt_q} + 1'b1;

    // Cell timing, bit sequencing and the registered drive output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q        <= '0;
            cnt_q       <= '0;
            idx_q       <= '0;
            busy_o      <= 1'b0;
            drive_low_o <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (abort_i) begin
                busy_o      <= 1'b0;
                drive_low_o <= 1'b0;
            end else if (start_i) begin
                busy_o      <= 1'b1;
                sh_q        <= data_i;
                cnt_q       <= '0;
                idx_q       <= '0;
                drive_low_o <= 1'b1;
            end else if (busy_o) begin
                if (cnt_q == CW'(CELL - 1)) begin
                    if (idx_q == last_idx) begin
                        busy_o      <= 1'b0;
                        drive_low_o <= 1'b0;
                        done_o      <= 1'b1;
                    end else begin
                        idx_q       <= idx_q + 1'b1;
                        cnt_q       <= '0;
                        sh_q        <= sh_q >> 1;
                        drive_low_o <= 1'b1;
                    end
                end else begin
                    cnt_q       <= cnt_nx[CW-1:0];
                    drive_low_o <= (cnt_nx < low_len);
                end
            end
        end
    end

endmodule

// File: rtl/swt_regfile.sv
// Register file with two bus write ports, one local write port and three
// combinational read ports. When several ports write the same entry in
// one cycle, port A wins, then port B, then the local port.
// Reset clears every entry.
module swt_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic          wl_en,
    input  logic [AW-1:0] wl_addr,
    input  logic [DW-1:0] wl_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic [AW-1:0] rl_addr,
    output logic [DW-1:0] rl_data
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Per-entry write with fixed port priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wa_en && wa_addr == AW'(i))
                mem[i] <= wa_data;
            else if (wb_en && wb_addr == AW'(i))
                mem[i] <= wb_data;
            else if (wl_en && wl_addr == AW'(i))
                mem[i] <= wl_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign rl_data = mem[rl_addr];

endmodule

// File: rtl/swt_target.sv
// Single-wire serial target responder (top).
// Decodes commands of 7 address bits plus a direction flag (1 = write), then
// stores 8/16 write bits or replies with 8/16 bits REPLY_DELAY cycles after
// the direction bit's falling edge. Assumes REPLY_DELAY >= CELL, a host
// that stays quiet during the reply, and wide_i stable within a transaction.
module swt_target #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int ONE_MAX_LOW = 8,
    parameter int BREAK_LOW   = 40,
    parameter int CELL        = 20,
    parameter int TX_LOW_ONE  = 4,
    parameter int TX_LOW_ZERO = 12,
    parameter int REPLY_DELAY = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              drive_low_o,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] loc_addr_i,
    input  logic              loc_wr_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    output logic [DATA_W-1:0] loc_rdata_o
);
    import swt_pkg::*;

    localparam int WW  = 2 * DATA_W;
    localparam int BCW = $clog2(WW);
    localparam int SFW = $clog2(REPLY_DELAY + 1);

    swt_state_e        state_q;
    logic [BCW-1:0]    cnt_q;
    logic [ADDR_W-1:0] cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WW-2:0]     dsh_q;
    logic [WW-1:0]     dsh_nx;
    logic [SFW-1:0]    sf_q;
    logic [BCW-1:0]    last_data;

    logic rx_fall, rx_vld, rx_bit, rx_brk;
    logic tx_start, tx_busy, tx_done;
    logic wr_go;
    logic [DATA_W-1:0] ra_data, rb_data, wa_data;
    logic [ADDR_W-1:0] addr_nx;

    assign addr_nx   = addr_q + 1'b1;
    assign dsh_nx    = {rx_bit, dsh_q};
    assign last_data = wide_i ? BCW'(WW - 1) : BCW'(DATA_W - 1);
    assign wr_go     = (state_q == ST_WDATA) && rx_vld && (cnt_q == last_data);
    assign wa_data   = wide_i ? dsh_nx[DATA_W-1:0] : dsh_nx[WW-1:DATA_W];
    assign tx_start  = (state_q == ST_WAIT) && (sf_q == SFW'(REPLY_DELAY - 1));

    swt_rx #(
        .ONE_MAX_LOW(ONE_MAX_LOW),
        .BREAK_LOW  (BREAK_LOW)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .mute_i   (drive_low_o),
        .fall_o   (rx_fall),
        .bit_vld_o(rx_vld),
        .bit_o    (rx_bit),
        .brk_o    (rx_brk)
    );

    swt_tx #(
        .CELL    (CELL),
        .LOW_ONE (TX_LOW_ONE),
        .LOW_ZERO(TX_LOW_ZERO),
        .DW      (WW)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (tx_start),
        .abort_i    (rx_brk),
        .wide_i     (wide_i),
        .data_i     ({rb_data, ra_data}),
        .drive_low_o(drive_low_o),
        .busy_o     (tx_busy),
        .done_o     (tx_done)
    );

    swt_regfile #(
        .AW(ADDR_W),
        .DW(DATA_W)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wa_en  (wr_go),
        .wa_addr(addr_q),
        .wa_data(wa_data),
        .wb_en  (wr_go & wide_i),
        .wb_addr(addr_nx),
        .wb_data(dsh_nx[WW-1:DATA_W]),
        .wl_en  (loc_wr_i),
        .wl_addr(loc_addr_i),
        .wl_data(loc_wdata_i),
        .ra_addr(addr_q),
        .ra_data(ra_data),
        .rb_addr(addr_nx),
        .rb_data(rb_data),
        .rl_addr(loc_addr_i),
        .rl_data(loc_rdata_o)
    );

    // Cycles since the last foreign falling edge, saturating at the delay
    always_ff @(posedge clk) begin
        if (!rst_n)
            sf_q <= '0;
        else if (rx_fall)
            sf_q <= '0;
        else if (sf_q != SFW'(REPLY_DELAY))
            sf_q <= sf_q + 1'b1;
    end

    // Transaction sequencing: command, write data, reply wait, reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            dsh_q   <= '0;
        end else if (rx_brk) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_CMD: if (rx_vld) begin
                    if (cnt_q == BCW'(ADDR_W)) begin
                        cnt_q   <= '0;
                        addr_q  <= cmd_q;
                        state_q <= rx_bit ? ST_WDATA : ST_WAIT;
                    end else begin
                        cmd_q <= {rx_bit, cmd_q[ADDR_W-1:1]};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WDATA: if (rx_vld) begin
                    dsh_q <= dsh_nx[WW-1:1];
                    if (cnt_q == last_data) begin
                        cnt_q   <= '0;
                        state_q <= ST_CMD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT: if (tx_start) state_q <= ST_SEND;
                ST_SEND: if (tx_done)  state_q <= ST_CMD;
                default: state_q <= ST_CMD;
            endcase
        end
    end

endmodule

// File: rtl/swt_target_chk.sv
// Protocol checker for swt_target, attached with bind.
// Keeps its own edge-to-edge and pulse-length counters.
module swt_target_chk #(
    parameter int REPLY_DELAY = 24,
    parameter int TX_LOW_ONE  = 4,
    parameter int TX_LOW_ZERO = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                line_i,
    input logic                drive_low_o,
    input logic                tx_busy,
    input logic                brk,
    input swt_pkg::swt_state_e state
);
    import swt_pkg::*;

    logic        lprev_q;
    logic [15:0] fcnt_q;
    logic [15:0] run_q;

    // Independent count of cycles since a foreign falling edge, and of drive-low run length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lprev_q <= 1'b1;
            fcnt_q  <= '0;
            run_q   <= '0;
        end else begin
            lprev_q <= line_i;
            if (lprev_q && !line_i && !drive_low_o)
                fcnt_q <= '0;
            else if (fcnt_q != 16'hFFFF)
                fcnt_q <= fcnt_q + 1'b1;
            run_q <= drive_low_o ? run_q + 1'b1 : '0;
        end
    end

    // R5: reply starts exactly REPLY_DELAY cycles after the direction bit falls
    a_r5_reply_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> fcnt_q == 16'(REPLY_DELAY));

    // R7: every drive pulse has one of the two legal lengths
    a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low_o) |-> (run_q == 16'(TX_LOW_ONE) || run_q == 16'(TX_LOW_ZERO)));

    // R7: the line is pulled only while a reply is in progress
    a_r7_drive_in_send: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low_o |-> state == ST_SEND);

    // R3: no drive while receiving write data
    a_r3_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WDATA |-> !drive_low_o);

    // R9: a break returns the sequencer to command collection
    a_r9_break_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> state == ST_CMD);

endmodule

bind swt_target swt_target_chk #(
    .REPLY_DELAY(REPLY_DELAY),
    .TX_LOW_ONE (TX_LOW_ONE),
    .TX_LOW_ZERO(TX_LOW_ZERO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_i),
    .drive_low_o(drive_low_o),
    .tx_busy    (tx_busy),
    .brk        (rx_brk),
    .state      (state_q)
);

// File: tb/swt_target_tb.sv
// Self-checking bench for swt_target: a vector table of bus transactions,
// then directed tests for reset, thresholds, long gaps and bus breaks.
module swt_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ONE_MAX    = 8;
    localparam int BRK        = 40;
    localparam int CELL_C     = 20;
    localparam int LOW1       = 4;
    localparam int LOW0       = 12;
    localparam int DLY        = 20;
    localparam int NVEC       = 6;

    // {wide, write, addr[6:0], data[15:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 7'h05, 16'h00A5},
        {1'b0, 1'b0, 7'h12, 16'h003C},
        {1'b0, 1'b1, 7'h7F, 16'h0081},
        {1'b0, 1'b0, 7'h00, 16'h00FF},
        {1'b1, 1'b1, 7'h7F, 16'hBEEF},
        {1'b1, 1'b0, 7'h40, 16'h1234}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       line;
    logic       drive_low;
    logic       wide = 1'b0;
    logic [6:0] loc_addr = '0;
    logic       loc_wr = 1'b0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;

    assign line = ~(host_low | drive_low);

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    swt_target #(
        .ONE_MAX_LOW(ONE_MAX), .BREAK_LOW(BRK), .CELL(CELL_C),
        .TX_LOW_ONE(LOW1), .TX_LOW_ZERO(LOW0), .REPLY_DELAY(DLY)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .drive_low_o(drive_low),
        .wide_i(wide), .loc_addr_i(loc_addr), .loc_wr_i(loc_wr),
        .loc_wdata_i(loc_wdata), .loc_rdata_o(loc_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input int low, input int gap);
        @(negedge clk) host_low = 1'b1;
        repeat (low) @(negedge clk);
        host_low = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n, input int gap);
        for (int i = 0; i < n; i++) pulse(v[i] ? 3 : 12, gap);
    endtask

    task automatic loc_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
        @(negedge clk) loc_wr = 1'b0;
    endtask

    task automatic loc_read(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk) loc_addr = a;
        #1 d = loc_rdata;
    endtask

    task automatic bus_write(input logic w, input logic [6:0] a, input logic [15:0] d, input int gap);
        wide = w;
        send_bits({8'h00, 1'b1, a}, 8, gap);
        send_bits(d, w ? 16 : 8, gap);
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_read(input logic w, input logic [6:0] a, output logic [15:0] d,
                            output int delay, output logic lens_ok);
        int n0, len;
        wide = w;
        d = '0; lens_ok = 1'b1; delay = -1;
        send_bits({9'h000, a}, 7, 10);
        @(negedge clk) host_low = 1'b1;
        n0 = cyc + 1;
        repeat (11) @(negedge clk);
        host_low = 1'b0;
        for (int i = 0; i < (w ? 16 : 8); i++) begin
            while (!drive_low) @(negedge clk);
            if (i == 0) delay = cyc - n0;
            len = 0;
            while (drive_low) begin len++; @(negedge clk); end
            d[i] = (len == LOW1);
            if (len != LOW1 && len != LOW0) lens_ok = 1'b0;
        end
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  b0, b1;
        logic [15:0] rd;
        int          dl;
        logic        ok;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 reset drive released", {15'd0, drive_low}, 16'd0);
        loc_read(7'h10, b0);
        check("R11 reset register cleared", {8'd0, b0}, 16'd0);

        // Table of transactions
        for (int v = 0; v < NVEC; v++) begin
            logic        vw, vwr;
            logic [6:0]  va;
            logic [15:0] vd;
            {vw, vwr, va, vd} = VEC[v];
            if (vwr) begin
                // R1 R3 R8 R10: write decoded (also after a preceding reply)
                bus_write(vw, va, vd, 10);
                loc_read(va, b0);
                check("R1 R3 R10 write low byte", {8'd0, b0}, {8'd0, vd[7:0]});
                if (vw) begin
                    loc_read(va + 7'd1, b1);
                    check("R8 write high byte wraps", {8'd0, b1}, {8'd0, vd[15:8]});
                end
            end else begin
                loc_write(va, vd[7:0]);
                if (vw) loc_write(va + 7'd1, vd[15:8]);
                bus_read(vw, va, rd, dl, ok);
                check(vw ? "R8 R4 wide read data" : "R4 R11 read data", rd,
                      vw ? vd : {8'd0, vd[7:0]});
                check("R5 reply delay", 16'(dl), 16'(DLY));
                check("R7 reply pulse lengths", {15'd0, ok}, 16'd1);
            end
        end

        // R2: threshold, 7-cycle low = 1, 8-cycle low = 0 -> 0x55
        wide = 1'b0;
        send_bits({8'h00, 1'b1, 7'h21}, 8, 10);
        for (int i = 0; i < 8; i++) pulse((i % 2 == 0) ? ONE_MAX - 1 : ONE_MAX, 10);
        repeat (5) @(negedge clk);
        loc_read(7'h21, b0);
        check("R2 pulse width threshold", {8'd0, b0}, 16'h0055);

        // R6: very long high gaps between bits
        bus_write(1'b0, 7'h0A, 16'h00C3, 500);
        loc_read(7'h0A, b0);
        check("R6 long gaps", {8'd0, b0}, 16'h00C3);

        // R9: partial command then break, then a clean write
        send_bits(16'h0005, 3, 10);
        pulse(BRK + 10, 10);
        bus_write(1'b0, 7'h33, 16'h005A, 10);
        loc_read(7'h33, b0);
        check("R9 break then write", {8'd0, b0}, 16'h005A);

        // R9: break during write data leaves the register untouched
        loc_write(7'h34, 8'h11);
        send_bits({8'h00, 1'b1, 7'h34}, 8, 10);
        send_bits(16'h00FF, 4, 10);
        pulse(BRK + 10, 10);
        repeat (5) @(negedge clk);
        loc_read(7'h34, b0);
        check("R9 aborted write ignored", {8'd0, b0}, 16'h0011);

        // R10: read then immediate read, own edges not decoded
        loc_write(7'h55, 8'h9D);
        bus_read(1'b0, 7'h55, rd, dl, ok);
        bus_read(1'b0, 7'h55, rd, dl, ok);
        check("R10 back-to-back read", rd, 16'h009D);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule